// File: doc/BRIEF.md
# Radix-16 Iterative Multiplier

This block is a sequential unsigned multiplier. Each clock it takes one hexadecimal digit (four bits) of the multiplier and adds up to four shifted copies of the multiplicand to a double-width accumulator. A radix-2 shift-add loop needs one cycle per multiplier bit. This block needs one cycle per four bits, so it finishes in a quarter of the iterations.

A client raises `start` for one cycle with two operands and a mode. It then sees `busy` until a one-cycle `done` pulse, and reads the full double-width product. The product stays unchanged until the next operation finishes. The mode input selects one of three jobs:

- a half-width integer multiply;
- a full-width integer multiply;
- a significand multiply, in which fixed-point mantissas are loaded as integers and the loop runs the full digit count.

Exponents, rounding and normalisation are left to the floating-point logic around the block.

Top module: `mul16_iter`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled while the block is idle makes `busy` 1 from the next cycle. `busy` stays 1 until the cycle in which `done` is 1, and is 0 in that cycle.
- R3: Mode 2'b01 (full integer): both W-bit operands are used unsigned and `product` equals the exact 2W-bit product. `done` rises after the (W/4+1)-th rising edge that follows the start edge (17 for W=64).
- R4: Mode 2'b00 (half integer): only bits [W/2-1:0] of each operand are used and the upper bits have no effect. The product is their exact unsigned product, and `done` rises after the (W/8+1)-th edge (9 for W=64).
- R5: Mode 2'b10 (significand): only bits [SIG_W-1:0] of each operand are used (SIG_W=53 by default). The loop runs the full W/4 iterations and `done` rises after the (W/4+1)-th edge.
- R6: Mode 2'b11 behaves exactly as mode 2'b01, in both result and timing.
- R7: `done` is high for exactly one cycle per accepted operation.
- R8: `product` changes only in the cycle in which `done` is 1, and otherwise holds its value, including while a later operation is running.
- R9: A `start` raised while `busy` is 1 is ignored. It changes neither the result nor the timing of the operation in progress, and it does not queue a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 2 | 00 half integer, 01 full integer, 10 significand, 11 as 01 |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Unsigned double-width product |

## Verification
Several operand pairs exercise the digit adder on every combination of set digit bits:

- all-ones operands, where every digit is 0xF and all four shifted copies are added each cycle;
- zero and one operands, which show the conditional terms being left out;
- mixed constants, where the digits vary from cycle to cycle.

The half-width and significand modes are driven with garbage in the upper operand bits, which separates correct masking from leakage. A start pulse in the middle of a run, and a start that coincides with `done`, separate ignored requests from accepted ones. Every cycle is compared against a behavioural countdown model, so a wrong iteration count shows up as a `done` cycle that arrives early or late.

// File: rtl/mul16_pkg.sv
package mul16_pkg;
    localparam int unsigned DIGIT_BITS = 4;

    typedef enum logic [1:0] {
        MODE_HALF = 2'b00,
        MODE_FULL = 2'b01,
        MODE_SIG  = 2'b10,
        MODE_ALT  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_WB   = 2'b10
    } state_e;

    // digit iterations needed for a given mode and operand width
    function automatic int unsigned iter_count(input mode_e m, input int unsigned w);
        return (m == MODE_HALF) ? w / (2 * DIGIT_BITS) : w / DIGIT_BITS;
    endfunction
endpackage

// File: rtl/mul16_digit_add.sv
module mul16_digit_add
    import mul16_pkg::*;
#(
    parameter int unsigned PW = 128
) (
    input  logic [PW-1:0]         acc,
    input  logic [PW-1:0]         mcand,
    input  logic [DIGIT_BITS-1:0] digit,
    output logic [PW-1:0]         sum
);
    localparam int unsigned NPAIR = DIGIT_BITS / 2;

    logic [PW-1:0] term [DIGIT_BITS];
    logic [PW-1:0] pair [NPAIR];

    // one conditionally shifted multiplicand copy per digit bit
    for (genvar i = 0; i < DIGIT_BITS; i++) begin : g_term
        assign term[i] = digit[i] ? (mcand << i) : '0;
    end

    // first level of the tree adds neighbouring copies
    for (genvar j = 0; j < NPAIR; j++) begin : g_pair
        assign pair[j] = term[2*j] + term[2*j+1];
    end

    always_comb begin
        sum = acc;
        for (int k = 0; k < NPAIR; k++) begin
            sum = sum + pair[k];
        end
    end
endmodule

// File: rtl/mul16_ctrl.sv
module mul16_ctrl
    import mul16_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  mode_e mode,
    output logic  busy,
    output logic  done,
    output logic  load,
    output logic  step
);
    localparam int unsigned MAX_IT = W / DIGIT_BITS;
    localparam int unsigned CW     = $clog2(MAX_IT + 1);

    state_e        state;
    logic [CW-1:0] cnt;

    assign busy = (state != ST_IDLE);
    assign load = (state == ST_IDLE) && start;
    assign step = (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    cnt   <= CW'(iter_count(mode, W));
                end
                ST_RUN: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == CW'(1)) state <= ST_WB;
                end
                ST_WB: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r2_idle_on_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (step && cnt > CW'(1)) |=> (step && cnt == $past(cnt) - 1'b1));
    a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
        step |-> (cnt != '0 && cnt <= CW'(MAX_IT)));
endmodule

// File: rtl/mul16_iter.sv
module mul16_iter
    import mul16_pkg::*;
#(
    parameter int unsigned W     = 64,
    parameter int unsigned SIG_W = 53
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [1:0]     mode,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    localparam int unsigned PW = 2 * W;
    localparam logic [W-1:0] HALF_MASK = {{(W - W/2){1'b0}}, {(W/2){1'b1}}};
    localparam logic [W-1:0] SIG_MASK  = {{(W - SIG_W){1'b0}}, {SIG_W{1'b1}}};

    mode_e         mode_q;
    logic          load, step;
    logic [W-1:0]  mask;
    logic [PW-1:0] acc, mcand, acc_next;
    logic [W-1:0]  mplier;

    assign mode_q = mode_e'(mode);

    always_comb begin
        unique case (mode_q)
            MODE_HALF: mask = HALF_MASK;
            MODE_SIG:  mask = SIG_MASK;
            default:   mask = '1;
        endcase
    end

    mul16_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .mode  (mode_q),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .step  (step)
    );

    mul16_digit_add #(.PW(PW)) u_add (
        .acc   (acc),
        .mcand (mcand),
        .digit (mplier[DIGIT_BITS-1:0]),
        .sum   (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            mcand   <= '0;
            mplier  <= '0;
            product <= '0;
        end else begin
            if (load) begin
                acc    <= '0;
                mcand  <= {{W{1'b0}}, op_a & mask};
                mplier <= op_b & mask;
            end else if (step) begin
                acc    <= acc_next;
                mcand  <= mcand << DIGIT_BITS;
                mplier <= mplier >> DIGIT_BITS;
            end
            if (busy && !step) product <= acc;
        end
    end

    a_r8_product_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(product) |-> done);
    a_r3_zero_digits_idle_add: assert property (@(posedge clk) disable iff (rst)
        (step && mplier == '0) |=> $stable(acc));
endmodule

// File: tb/mul16_iter_tb.sv
module mul16_iter_tb;
    localparam int unsigned W     = 64;
    localparam int unsigned SIG_W = 53;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [1:0]     mode = 2'b01;
    logic [W-1:0]   op_a = '0, op_b = '0;
    logic           busy, done;
    logic [2*W-1:0] product;

    always #10 clk = ~clk;

    mul16_iter #(.W(W), .SIG_W(SIG_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .product(product)
    );

    int n_vec = 0, n_bad = 0, cycles = 0;
    string cur_tag = "R1";

    // behavioural reference
    logic           m_busy = 1'b0, m_done = 1'b0;
    logic [2*W-1:0] m_prod = '0, m_pend = '0;
    int             m_left = 0;

    function automatic logic [W-1:0] mask_for(input logic [1:0] md);
        if (md == 2'b00) return {{(W/2){1'b0}}, {(W/2){1'b1}}};
        if (md == 2'b10) return {{(W-SIG_W){1'b0}}, {SIG_W{1'b1}}};
        return '1;
    endfunction

    always @(posedge clk) begin
        m_done = 1'b0;
        if (rst) begin
            m_busy = 1'b0; m_prod = '0; m_left = 0;
        end else if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
                m_busy = 1'b0; m_done = 1'b1; m_prod = m_pend;
            end
        end else if (start) begin
            m_busy = 1'b1;
            m_left = ((mode == 2'b00) ? W/8 : W/4) + 1;
            m_pend = {{W{1'b0}}, op_a & mask_for(mode)} * {{W{1'b0}}, op_b & mask_for(mode)};
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        n_vec++;
        if (busy !== m_busy) begin
            n_bad++;
            $display("FAIL %s busy: got %b expected %b", rst ? "R1" : "R2", busy, m_busy);
        end
        if (done !== m_done) begin
            n_bad++;
            $display("FAIL %s done: got %b expected %b", rst ? "R1" : "R7", done, m_done);
        end
        if (product !== m_prod) begin
            n_bad++;
            $display("FAIL %s product: got %h expected %h", rst ? "R1" : cur_tag, product, m_prod);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic run_op(input logic [1:0] md, input logic [W-1:0] a, input logic [W-1:0] b,
                          input string tag);
        @(negedge clk);
        cur_tag = tag; start = 1'b1; mode = md; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        cur_tag = tag;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3, "R1");          // R1 checked while rst high
        rst = 1'b0;
        idle(2, "R1");          // R1 checked just after release

        // R3: full-width integer patterns
        run_op(2'b01, '1, '1, "R3");
        run_op(2'b01, 64'h0, 64'hDEAD_BEEF_0123_4567, "R3");
        run_op(2'b01, 64'h1, 64'h8000_0000_0000_0001, "R3");
        run_op(2'b01, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R3");
        idle(6, "R8");          // R8: product must hold while idle

        // R4: half mode, upper bits are garbage
        run_op(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_A5A5_FFFF_FFFF, "R4");
        run_op(2'b00, 64'h1234_5678_0000_0003, 64'h9999_0000_8000_0007, "R4");

        // R5: significand mode, bits above SIG_W ignored
        run_op(2'b10, 64'hFFF0_0000_0000_0001 | 64'h001F_FFFF_FFFF_FFFF,
                      64'hFFE8_0000_0000_0000, "R5");
        run_op(2'b10, 64'h0010_0000_0000_0000, 64'h0018_0000_0000_0000, "R5");

        // R6: mode 11 acts as full mode
        run_op(2'b11, 64'hCAFE_F00D_1357_9BDF, 64'h0F0F_0F0F_F0F0_F0F0, "R6");

        // R9: start during busy is ignored
        @(negedge clk);
        cur_tag = "R9"; start = 1'b1; mode = 2'b01;
        op_a = 64'h0000_0000_0000_0007; op_b = 64'h0000_0000_0000_0009;
        @(negedge clk);
        start = 1'b0;
        idle(4, "R9");
        start = 1'b1; mode = 2'b00; op_a = '1; op_b = '1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        idle(3, "R8");

        // R2/R7: start in the same cycle as done
        @(negedge clk);
        cur_tag = "R2"; start = 1'b1; mode = 2'b00; op_a = 64'h5; op_b = 64'h6;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        start = 1'b1; mode = 2'b01; op_a = 64'hFFFF_0000_FFFF_0000; op_b = 64'h3;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        idle(4, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule